// File: doc/BRIEF.md
# Ping-Pong / Circular Buffer Address Sequencer

This block generates system-memory word addresses for one logical channel's data transfers. Each accepted transfer strobe moves the address forward by one 32-bit word. A buffer runs from its first byte address to its last byte address, and the last address is included in the buffer. What happens when the last word of a buffer is used depends on the buffering mode latched when the channel starts.

**Ping-pong mode**

- Transfers move on to a second buffer and a sticky interrupt is raised.
- Software reloads the spare buffer slot with the next region. The region can therefore be different for every buffer.
- If no spare region is ready at the switch, the sequencer stalls. It raises a stall status and does not reuse stale addresses.

**Circular mode**

- One region is traversed again and again, with no interrupt.
- It runs until software drops the ready input.
- This mode is accepted only for synchronous-type channels. Any other channel type is refused with a configuration error.

Dropping the ready input stops the channel at the next word boundary. A word strobed in that same cycle is still completed.

Top module: `bufseq_top`

## Requirements
- R1: After reset, `busy`, `sw_irq`, `stall` and `cfg_err` are 0 and `cur_addr` is 0.
- R2: While idle and with no configuration error, `ready`=1 starts the channel. One cycle later `busy`=1 and `cur_addr` equals `start_addr`. `mode_sel` (0 = ping-pong, 1 = circular) is latched at that start.
- R3: While running, a `xfer` strobe at an address other than the buffer's last address makes `cur_addr` increase by 4 in the next cycle.
- R4: In ping-pong mode, a strobe at the last address with a spare region loaded (`nxt_load` writes `nxt_first`/`nxt_last` into the slot) switches to that region. One cycle later `cur_addr` equals its first address and `sw_irq`=1. The slot is then empty.
- R5: `sw_irq` stays at 1 until `irq_clr`=1. When a buffer switch and `irq_clr` occur in the same cycle, the switch wins.
- R6: In ping-pong mode, a strobe at the last address with an empty slot and no `nxt_load` does two things. `stall` becomes 1 and `cur_addr` holds, and further strobes do not change it. A later `nxt_load` resumes at `nxt_first` one cycle later, with `sw_irq`=1 and `stall`=0.
- R7: In ping-pong mode, an `nxt_load` in the same cycle as a strobe at the last address, with the slot empty, switches directly to the incoming region without stalling.
- R8: In circular mode, a strobe at `end_addr` returns `cur_addr` to `start_addr` one cycle later, and `sw_irq` is never raised.
- R9: A start request with `mode_sel`=1 and `sync_chan`=0 is refused. `cfg_err`=1 and `busy` stays 0 until `ready` falls, and `cfg_err` clears one cycle after `ready` falls.
- R10: With `ready`=0 while running, a strobe in that cycle still advances the address. `busy` is 0 in the next cycle, and later strobes leave `cur_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = ping-pong, 1 = circular |
| sync_chan | input | 1 | Channel is synchronous-type |
| ready | input | 1 | Channel enable from software |
| start_addr | input | ADDR_W | First byte address of the initial/circular region |
| end_addr | input | ADDR_W | Last (inclusive) word address of that region |
| nxt_first | input | ADDR_W | First address of the next ping-pong region |
| nxt_last | input | ADDR_W | Last address of the next ping-pong region |
| nxt_load | input | 1 | Write strobe for the next-region slot |
| xfer | input | 1 | One-word transfer strobe |
| irq_clr | input | 1 | Write-1 clear of the switch interrupt |
| cur_addr | output | ADDR_W | Current transfer address |
| sw_irq | output | 1 | Sticky buffer-switch interrupt |
| busy | output | 1 | Channel running or stalled |
| stall | output | 1 | Ping-pong switch found no next region |
| cfg_err | output | 1 | Circular mode refused on a non-synchronous channel |

## Verification
Software's reload of the next region can land in the very cycle the transfer strobe consumes the last word of a buffer. The interrupt clear can also land in that cycle. The bench provokes both together: it starts from an empty slot and a cleared interrupt, and pulses `nxt_load` and `irq_clr` on the final strobe of a buffer. It judges the result one cycle later. `stall` must be 0, `cur_addr` must equal the incoming region's first address, and `sw_irq` must be 1. A second run loads the slot ahead of time and leaves the buffer unrefilled. That run shows the opposite outcome, which is a stall with a frozen address.

// File: rtl/bufseq_pkg.sv
package bufseq_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic {
        BM_PINGPONG = 1'b0,
        BM_CIRCULAR = 1'b1
    } buf_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_STALL = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_SLOT = 2'd1,
        SRC_IN   = 2'd2
    } region_src_e;

    function automatic logic circ_allowed(input logic circ, input logic sync);
        return !circ || sync;
    endfunction

endpackage

// File: rtl/bufseq_slot.sv
module bufseq_slot #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              take,
    input  logic [ADDR_W-1:0] wr_first,
    input  logic [ADDR_W-1:0] wr_last,
    output logic              valid,
    output logic [ADDR_W-1:0] first,
    output logic [ADDR_W-1:0] last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            first <= '0;
            last  <= '0;
        end else if (wr) begin
            valid <= 1'b1;
            first <= wr_first;
            last  <= wr_last;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    AST_SLOT_FILL: assert property (@(posedge clk) disable iff (rst)
        wr |=> valid); // R4

    AST_SLOT_DRAIN: assert property (@(posedge clk) disable iff (rst)
        take && !wr |=> !valid); // R4

endmodule

// File: rtl/bufseq_addr.sv
module bufseq_addr
    import bufseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_ld,
    input  logic [ADDR_W-1:0] reg_first,
    input  logic [ADDR_W-1:0] reg_last,
    input  logic              wrap,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] first_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            first_q <= '0;
            last_q  <= '0;
        end else if (reg_ld) begin
            addr    <= reg_first;
            first_q <= reg_first;
            last_q  <= reg_last;
        end else if (wrap) begin
            addr <= first_q;
        end else if (inc) begin
            addr <= addr + STEP;
        end
    end

    assign at_last = (addr == last_q);

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_ld && !wrap && !inc |=> $stable(addr)); // R6

    AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (rst)
        wrap && !reg_ld |=> addr == first_q); // R8

endmodule

// File: rtl/bufseq_ctrl.sv
module bufseq_ctrl
    import bufseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_sel,
    input  logic        sync_chan,
    input  logic        ready,
    input  logic        xfer,
    input  logic        nxt_load,
    input  logic        irq_clr,
    input  logic        at_last,
    input  logic        slot_valid,
    output logic        reg_ld,
    output region_src_e src,
    output logic        wrap,
    output logic        inc,
    output logic        slot_take,
    output logic        slot_wr,
    output logic        sw_irq,
    output logic        busy,
    output logic        stall,
    output logic        cfg_err
);

    seq_state_e state, nxt_state;
    buf_mode_e  mode_q;
    logic       sw, bypass, cfg_set;

    always_comb begin
        nxt_state = state;
        reg_ld    = 1'b0;
        src       = SRC_EXT;
        wrap      = 1'b0;
        inc       = 1'b0;
        slot_take = 1'b0;
        sw        = 1'b0;
        bypass    = 1'b0;
        cfg_set   = 1'b0;
        case (state)
            SQ_IDLE: begin
                if (ready && !cfg_err) begin
                    if (!circ_allowed(mode_sel, sync_chan)) begin
                        cfg_set = 1'b1;
                    end else begin
                        reg_ld    = 1'b1;
                        src       = SRC_EXT;
                        nxt_state = SQ_RUN;
                    end
                end
            end
            SQ_RUN: begin
                if (xfer) begin
                    if (!at_last) begin
                        inc = 1'b1;
                    end else if (mode_q == BM_CIRCULAR) begin
                        wrap = 1'b1;
                    end else if (slot_valid) begin
                        reg_ld    = 1'b1;
                        src       = SRC_SLOT;
                        slot_take = 1'b1;
                        sw        = 1'b1;
                    end else if (nxt_load) begin
                        reg_ld = 1'b1;
                        src    = SRC_IN;
                        bypass = 1'b1;
                        sw     = 1'b1;
                    end else begin
                        nxt_state = SQ_STALL;
                    end
                end
                if (!ready) nxt_state = SQ_IDLE;
            end
            SQ_STALL: begin
                if (!ready) begin
                    nxt_state = SQ_IDLE;
                end else if (nxt_load) begin
                    reg_ld    = 1'b1;
                    src       = SRC_IN;
                    bypass    = 1'b1;
                    sw        = 1'b1;
                    nxt_state = SQ_RUN;
                end
            end
            default: nxt_state = SQ_IDLE;
        endcase
    end

    assign slot_wr = nxt_load && !bypass;
    assign busy    = (state != SQ_IDLE);
    assign stall   = (state == SQ_STALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            mode_q  <= BM_PINGPONG;
            sw_irq  <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            state <= nxt_state;
            if (state == SQ_IDLE && reg_ld) mode_q <= buf_mode_e'(mode_sel);
            if (sw)           sw_irq <= 1'b1;
            else if (irq_clr) sw_irq <= 1'b0;
            if (!ready)       cfg_err <= 1'b0;
            else if (cfg_set) cfg_err <= 1'b1;
        end
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        sw_irq && !irq_clr |=> sw_irq); // R5

    AST_SWITCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sw && irq_clr |=> sw_irq); // R5

    AST_STALL_ONLY_PP: assert property (@(posedge clk) disable iff (rst)
        stall |-> mode_q == BM_PINGPONG); // R6

    AST_CIRC_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        busy && mode_q == BM_CIRCULAR && !sw_irq |=> !sw_irq); // R8

    AST_CFG_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy); // R9

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        busy && !ready |=> !busy); // R10

endmodule

// File: rtl/bufseq_top.sv
module bufseq_top
    import bufseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              sync_chan,
    input  logic              ready,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [ADDR_W-1:0] nxt_first,
    input  logic [ADDR_W-1:0] nxt_last,
    input  logic              nxt_load,
    input  logic              xfer,
    input  logic              irq_clr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              sw_irq,
    output logic              busy,
    output logic              stall,
    output logic              cfg_err
);

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
    } region_t;

    region_t     slot_r, sel_r;
    logic        slot_valid, slot_wr, slot_take;
    logic        reg_ld, wrap, inc, at_last;
    region_src_e src;

    bufseq_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .wr       (slot_wr),
        .take     (slot_take),
        .wr_first (nxt_first),
        .wr_last  (nxt_last),
        .valid    (slot_valid),
        .first    (slot_r.first),
        .last     (slot_r.last)
    );

    always_comb begin
        case (src)
            SRC_SLOT: sel_r = slot_r;
            SRC_IN:   sel_r = '{first: nxt_first, last: nxt_last};
            default:  sel_r = '{first: start_addr, last: end_addr};
        endcase
    end

    bufseq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .reg_ld    (reg_ld),
        .reg_first (sel_r.first),
        .reg_last  (sel_r.last),
        .wrap      (wrap),
        .inc       (inc),
        .addr      (cur_addr),
        .at_last   (at_last)
    );

    bufseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .sync_chan  (sync_chan),
        .ready      (ready),
        .xfer       (xfer),
        .nxt_load   (nxt_load),
        .irq_clr    (irq_clr),
        .at_last    (at_last),
        .slot_valid (slot_valid),
        .reg_ld     (reg_ld),
        .src        (src),
        .wrap       (wrap),
        .inc        (inc),
        .slot_take  (slot_take),
        .slot_wr    (slot_wr),
        .sw_irq     (sw_irq),
        .busy       (busy),
        .stall      (stall),
        .cfg_err    (cfg_err)
    );

endmodule

// File: tb/test_bufseq_top.sv
`timescale 1ns/1ps
module test_bufseq_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_sel = 1'b0, sync_chan = 1'b1, ready = 1'b0;
    logic [AW-1:0] start_addr = '0, end_addr = '0, nxt_first = '0, nxt_last = '0;
    logic          nxt_load = 1'b0, xfer = 1'b0, irq_clr = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          sw_irq, busy, stall, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bufseq_top #(.ADDR_W(AW)) i_bufseq_top (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .sync_chan(sync_chan),
        .ready(ready), .start_addr(start_addr), .end_addr(end_addr),
        .nxt_first(nxt_first), .nxt_last(nxt_last), .nxt_load(nxt_load),
        .xfer(xfer), .irq_clr(irq_clr), .cur_addr(cur_addr), .sw_irq(sw_irq),
        .busy(busy), .stall(stall), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq", int'(sw_irq), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R1 addr", int'(cur_addr), 0);

        // Ping-pong sweep over region lengths
        for (int l0 = 1; l0 <= 3; l0++) begin
            for (int l1 = 1; l1 <= 3; l1++) begin
                int a = 'h100 + 'h10 * l0;
                int b = 'h200 + 'h10 * l1;
                int c = 'h300;
                mode_sel = 1'b0;
                ready = 1'b0; xfer = 1'b0;
                step();
                clear_irq();
                start_addr = AW'(a); end_addr = AW'(a + 4 * (l0 - 1));
                nxt_first = AW'(b); nxt_last = AW'(b + 4 * (l1 - 1));
                nxt_load = 1'b1; step(); nxt_load = 1'b0;
                ready = 1'b1; step();
                chk("R2 busy", int'(busy), 1);
                chk("R2 start addr", int'(cur_addr), a);
                xfer = 1'b1;
                for (int i = 0; i < l0; i++) begin
                    chk("R3 step addr", int'(cur_addr), a + 4 * i);
                    step();
                end
                xfer = 1'b0;
                chk("R4 switch addr", int'(cur_addr), b);
                chk("R4 irq", int'(sw_irq), 1);
                step();
                chk("R5 irq held", int'(sw_irq), 1);
                clear_irq();
                chk("R5 irq cleared", int'(sw_irq), 0);
                xfer = 1'b1;
                for (int i = 0; i < l1; i++) begin
                    chk("R4 second region", int'(cur_addr), b + 4 * i);
                    step();
                end
                chk("R6 stall", int'(stall), 1);
                chk("R6 addr frozen", int'(cur_addr), b + 4 * (l1 - 1));
                step();
                xfer = 1'b0;
                chk("R6 strobe ignored", int'(cur_addr), b + 4 * (l1 - 1));
                chk("R6 irq not set", int'(sw_irq), 0);
                nxt_first = AW'(c); nxt_last = AW'(c + 4);
                nxt_load = 1'b1; step(); nxt_load = 1'b0;
                chk("R6 resume stall", int'(stall), 0);
                chk("R6 resume addr", int'(cur_addr), c);
                chk("R6 resume irq", int'(sw_irq), 1);
                ready = 1'b0; step();
                chk("R10 idle", int'(busy), 0);
            end
        end

        // R7 + R5: load and irq clear in the same cycle as the boundary strobe
        clear_irq();
        mode_sel = 1'b0;
        start_addr = AW'('h500); end_addr = AW'('h504);
        ready = 1'b1; step();
        xfer = 1'b1; step();
        nxt_first = AW'('h600); nxt_last = AW'('h60c);
        nxt_load = 1'b1; irq_clr = 1'b1;
        step();
        nxt_load = 1'b0; irq_clr = 1'b0; xfer = 1'b0;
        chk("R7 no stall", int'(stall), 0);
        chk("R7 direct addr", int'(cur_addr), 'h600);
        chk("R5 switch wins over clear", int'(sw_irq), 1);
        // R10: strobe in the ready-drop cycle completes
        ready = 1'b0; xfer = 1'b1; step();
        chk("R10 last word done", int'(cur_addr), 'h604);
        chk("R10 busy low", int'(busy), 0);
        step();
        xfer = 1'b0;
        chk("R10 strobe ignored", int'(cur_addr), 'h604);

        // Circular sweep
        for (int len = 1; len <= 4; len++) begin
            int e = 'h700 + 'h40 * len;
            clear_irq();
            mode_sel = 1'b1; sync_chan = 1'b1;
            start_addr = AW'(e); end_addr = AW'(e + 4 * (len - 1));
            ready = 1'b1; step();
            chk("R2 circ busy", int'(busy), 1);
            xfer = 1'b1;
            for (int i = 0; i < 2 * len + 2; i++) begin
                chk("R8 wrap addr", int'(cur_addr), e + 4 * (i % len));
                step();
            end
            xfer = 1'b0;
            chk("R8 no irq", int'(sw_irq), 0);
            ready = 1'b0; step();
            chk("R10 circ stop", int'(busy), 0);
        end

        // R9: circular refused on non-synchronous channel
        mode_sel = 1'b1; sync_chan = 1'b0; ready = 1'b1;
        step();
        chk("R9 cfg_err", int'(cfg_err), 1);
        chk("R9 not busy", int'(busy), 0);
        step();
        chk("R9 still refused", int'(busy), 0);
        ready = 1'b0; step();
        chk("R9 cfg_err clears", int'(cfg_err), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule